// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a small two-wire serial memory holding 128 bytes. It watches the raw clock and data lines and brings both into one system clock through two-flop synchronisers. It detects start and stop conditions, shifts bytes in and out, and answers on the data line through an open-drain pull-down enable. A separate page write engine sits beside it and owns the storage array and the timed programming cycle. The engine receives every accepted write byte together with its target address, and gets one pulse when a write has ended. It returns array contents through a combinational read port, and reports a busy flag while it programs.

The control byte carries the fixed device code 1010 in its upper nibble, three select bits that must match the strap inputs, and a direction flag in bit 0. A write loads the single 7-bit address pointer from its second byte. The data bytes that follow target successive locations inside one 16-byte page. A read streams bytes from the pointer onward for as long as the master acknowledges. The block refuses every acknowledge while the engine is busy, so a master can poll for the end of a programming cycle.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the data-line enable is released, the write strobe and commit pulse are low, and the address pointer is 0, so a current-address read as the first command returns the byte at location 0.
- R2: A control byte is acknowledged on the ninth clock when bits 7..4 are 1010, bits 3..1 equal the select straps (bit 3 against strap bit 2), and the engine is not busy. Bit 0 selects a read when 1 and a write when 0.
- R3: A control byte with a wrong code or wrong select bits gets no acknowledge. The block then ignores the bus until the next start: it acknowledges no further byte and issues no write strobe.
- R4: While the busy input is high, nothing is acknowledged, not even a correctly addressed control byte. Once busy falls, the same control byte is acknowledged.
- R5: In a write, the byte after the control byte loads the pointer from its low 7 bits and is acknowledged. Each later complete data byte is acknowledged and presented for one clock on the write strobe, with the current pointer on the write address and the byte on the write data.
- R6: During a write the pointer advances after each data byte only in its low 4 bits, wrapping within the 16-byte page while the upper 3 bits stay fixed.
- R7: A stop (or start) that ends a write which carried at least one data byte produces exactly one commit pulse. A write that ends after only the address byte produces none.
- R8: A repeated start after the address byte keeps the newly loaded pointer, so the following read returns the byte at that address (random read).
- R9: A read returns the byte at the pointer, and the pointer then advances by one per byte sent, wrapping from 0x7F to 0x00. After a write it points to the location after the last byte written.
- R10: In a read, an acknowledge from the master makes the block send the next byte. A missing acknowledge makes it leave the data line released through later clocks until the next start.
- R11: The data-line enable changes only while the clock is low. Each change lands on the (HOLD_CLKS+3)-th system clock rising edge after the clock input falls: two synchroniser stages, one edge register, then the hold count.
- R12: A start or stop in the middle of a byte aborts it. A partial write byte is neither strobed nor committed, and a partial control byte is discarded, so a following full control byte is decoded afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line level |
| sda_in | input | 1 | Raw serial data line level (wired bus value) |
| sel_strap | input | 3 | Chip-select strap levels compared with control byte bits 3..1 |
| busy | input | 1 | Page write engine is programming; refuse all acknowledges |
| rd_data | input | 8 | Array byte at rd_addr, from the engine |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| rd_addr | output | 7 | Current address pointer, used as the array read address |
| wr_valid | output | 1 | One-clock strobe for an accepted write data byte |
| wr_addr | output | 7 | Target location of the strobed byte |
| wr_data | output | 8 | Strobed write data byte |
| wr_commit | output | 1 | One-clock pulse when a write carrying data ends |

## Verification
The bench goes after page wrap: a write starting near the end of a page must strobe addresses that fold back to the page base, and a design that carries into bit 4 would strobe 0x40 instead of 0x30. It reads across 0x7F to check the full-width pointer wrap there. It also covers the poll sequence, where a design that ignores busy acknowledges during programming, and the address-only write, where a loose commit rule starts a needless programming cycle. Aborted bytes are tested with stops and starts inserted after a few bits; a design that does not reset its bit count there would strobe garbage or misread the next control byte. A timing monitor measures every enable change against the clock fall before it, which catches a drive that moves at the wrong moment and could fake a start or stop.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_WDATA, ST_READ, ST_SKIP
  } sms_state_t;

  // Device code and select bits of a received control byte.
  function automatic logic ctrl_match(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_CODE) && (b[3:1] == sel);
  endfunction
endpackage

// File: rtl/sms_line_sync.sv
`timescale 1ns/1ps
module sms_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      // pipe[STAGES-1:0] is the synchroniser chain, pipe[STAGES] the previous level
      logic [STAGES:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], raw[g]};
      end
      assign lvl[g]  = pipe[STAGES-1];
      assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
      assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
    end
  endgenerate
endmodule

// File: rtl/sms_oe_timer.sv
`timescale 1ns/1ps
module sms_oe_timer #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  input  logic drive_req,
  output logic sda_oe
);
  localparam int TW = $clog2(HOLD + 1);

  logic [TW-1:0] tmr;
  logic          fire;

  assign fire = (tmr == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr    <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (scl_fall)        tmr <= TW'(HOLD);
      else if (tmr != '0)  tmr <= tmr - 1'b1;
      if (fire) sda_oe <= drive_req;
    end
  end

  // R11
  oe_timed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(tmr) == TW'(1));
endmodule

// File: rtl/sms_addr_ptr.sv
`timescale 1ns/1ps
module sms_addr_ptr #(
  parameter int AW = 7,
  parameter int PB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          wr_step,
  input  logic          rd_step,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] PAGE_MASK = {{(AW-PB){1'b0}}, {PB{1'b1}}};

  // Advance inside the page: only the masked low bits count.
  function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
    return (a & ~PAGE_MASK) | ((a + 1'b1) & PAGE_MASK);
  endfunction

  // Advance across the whole array with natural wrap.
  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= load_val;
    else if (wr_step) ptr <= page_next(ptr);
    else if (rd_step) ptr <= seq_next(ptr);
  end

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step && !load |=> ptr[AW-1:PB] == $past(ptr[AW-1:PB]));
  // R9
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step && !load && !wr_step |=> ptr == AW'($past(ptr) + 1'b1));
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !wr_step && !rd_step |=> $stable(ptr));
endmodule

// File: rtl/serial_mem_slave.sv
`timescale 1ns/1ps
module serial_mem_slave #(
  parameter int ADDR_W      = 7,
  parameter int PAGE_BITS   = 4,
  parameter int HOLD_CLKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        sel_strap,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  import sms_pkg::*;

  localparam int          CNT_W    = 4;
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(8);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(9);

  // ---------------- line conditioning ----------------
  logic [1:0] lvl, rise, fall;
  sms_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({sda_in, scl_in}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  logic scl_lvl, sda_lvl, scl_rise, scl_fall;
  logic start_ev, stop_ev;
  assign scl_lvl  = lvl[0];
  assign sda_lvl  = lvl[1];
  assign scl_rise = rise[0];
  assign scl_fall = fall[0];
  assign start_ev = fall[1] & scl_lvl;
  assign stop_ev  = rise[1] & scl_lvl;

  // ---------------- protocol state ----------------
  sms_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shreg;
  logic [7:0]       tx;
  logic             rw_read;
  logic             mack;
  logic             got_data;
  logic             drive_req;
  logic [ADDR_W-1:0] ptr;

  // Named decision points shared with the pointer and the assertions.
  logic at_fall8, at_fall9, ack_ok, ptr_load, wr_step, rd_step;
  always_comb begin
    at_fall8 = scl_fall && !start_ev && !stop_ev && (cnt == BIT_LAST);
    at_fall9 = scl_fall && !start_ev && !stop_ev && (cnt == ACK_DONE);
    unique case (state)
      ST_CTRL:           ack_ok = !busy && ctrl_match(shreg, sel_strap);
      ST_ADDR, ST_WDATA: ack_ok = !busy;
      default:           ack_ok = 1'b0;
    endcase
    ptr_load = at_fall8 && (state == ST_ADDR) && ack_ok;
    wr_step  = at_fall8 && (state == ST_WDATA) && ack_ok;
    rd_step  = at_fall8 && (state == ST_READ);
  end

  sms_addr_ptr #(.AW(ADDR_W), .PB(PAGE_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(shreg[ADDR_W-1:0]),
    .wr_step(wr_step), .rd_step(rd_step), .ptr(ptr)
  );
  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      rw_read   <= 1'b0;
      mack      <= 1'b0;
      got_data  <= 1'b0;
      drive_req <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (start_ev || stop_ev) begin
        // Any boundary condition ends the current transfer.
        if (got_data) wr_commit <= 1'b1;
        got_data  <= 1'b0;
        drive_req <= 1'b0;
        cnt       <= '0;
        state     <= start_ev ? ST_CTRL : ST_IDLE;
      end else if (scl_rise) begin
        if (state != ST_IDLE && state != ST_SKIP && cnt < ACK_DONE)
          cnt <= cnt + 1'b1;
        if ((state == ST_CTRL || state == ST_ADDR || state == ST_WDATA) && cnt < BIT_LAST)
          shreg <= {shreg[6:0], sda_lvl};
        if (state == ST_READ && cnt == BIT_LAST)
          mack <= !sda_lvl;
      end else if (scl_fall) begin
        unique case (state)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (at_fall8) begin
              if (ack_ok) begin
                drive_req <= 1'b1;
                if (state == ST_CTRL) rw_read <= shreg[0];
                if (state == ST_WDATA) begin
                  wr_valid <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= shreg;
                  got_data <= 1'b1;
                end
              end else begin
                state <= ST_SKIP;
              end
            end else if (at_fall9) begin
              cnt <= '0;
              if (state == ST_CTRL && rw_read) begin
                state     <= ST_READ;
                tx        <= rd_data;
                drive_req <= !rd_data[7];
              end else begin
                drive_req <= 1'b0;
                if (state == ST_CTRL) state <= ST_ADDR;
                else                  state <= ST_WDATA;
              end
            end
          end
          ST_READ: begin
            if (at_fall8) begin
              drive_req <= 1'b0;
            end else if (at_fall9) begin
              if (mack) begin
                tx        <= rd_data;
                drive_req <= !rd_data[7];
                cnt       <= '0;
              end else begin
                state     <= ST_SKIP;
                drive_req <= 1'b0;
              end
            end else if (cnt != '0) begin
              tx        <= {tx[6:0], 1'b0};
              drive_req <= !tx[6];
            end
          end
          default: ;
        endcase
      end
    end
  end

  sms_oe_timer #(.HOLD(HOLD_CLKS)) u_oe (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall),
    .drive_req(drive_req), .sda_oe(sda_oe)
  );

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_lvl);
  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !drive_req);
  // R4
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(at_fall8) && $past(state) != ST_READ) |-> !drive_req);
  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R7
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
endmodule

// File: tb/serial_mem_slave_test.sv
`timescale 1ns/1ps
module serial_mem_slave_test;
  localparam int HOLD  = 4;
  localparam int Q     = 10;
  localparam int BUSY_CLKS = 1500;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_valid, wr_commit;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] wr_data, rd_data;
  logic busy;
  wire  sda_bus = sda_m & ~sda_oe;

  serial_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sel_strap(STRAP), .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe),
    .rd_addr(rd_addr), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction
  function automatic logic [6:0] pg_next(input logic [6:0] a);
    return {a[6:4], 4'(a[3:0] + 4'd1)};
  endfunction
  function automatic logic [6:0] seq_nxt(input logic [6:0] a);
    return 7'((a + 7'd1) % 128);
  endfunction

  // ------------- page write engine model -------------
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [6:0] cap_addr [512];
  logic [7:0] cap_data [512];
  int cap_n = 0, commit_n = 0, busy_cnt = 0;
  assign busy    = (busy_cnt != 0);
  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
    end else begin
      if (wr_valid) begin
        mem[wr_addr] <= wr_data;
        if (cap_n < 512) begin
          cap_addr[cap_n] <= wr_addr;
          cap_data[cap_n] <= wr_data;
        end
        cap_n <= cap_n + 1;
      end
      if (wr_commit) begin
        commit_n <= commit_n + 1;
        busy_cnt <= BUSY_CLKS;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  // ------------- drive timing monitor (R11) -------------
  int   fall_age = 0, oe_bad = 0, oe_changes = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(posedge clk) begin
    if (prev_scl && !scl_m) fall_age <= 1;
    else                    fall_age <= fall_age + 1;
    prev_scl <= scl_m;
    if (rst_n && (sda_oe != prev_oe)) begin
      oe_changes <= oe_changes + 1;
      // registered on edge HOLD+3 after the fall, seen here one edge later
      if (scl_m || fall_age != HOLD + 3) oe_bad <= oe_bad + 1;
    end
    prev_oe <= sda_oe;
  end

  // ------------- checking -------------
  int n_chk = 0, n_fail = 0;
  logic [6:0] ptr_m = 7'd0;
  logic [7:0] wbuf [16];
  logic [6:0] exp_a [16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic seen);
    sda_m = b;  wq();
    scl_m = 1'b1; wq();
    seen = sda_bus;
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic send_bits(input int n, input logic [7:0] v);
    logic s;
    for (int i = n - 1; i >= 0; i--) put_bit(v[i], s);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s);
      b[i] = s;
    end
    put_bit(!give_ack, s);
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input bit wait_done, input string tag);
    logic ack;
    int c0, k0;
    logic [6:0] p;
    c0 = cap_n; k0 = commit_n;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    chk(ack, {"R2 write control ack ", tag}, ack, 1);
    send_byte({1'b0, a}, ack);
    chk(ack, {"R5 address ack ", tag}, ack, 1);
    p = a;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack, {"R5 data ack ", tag}, ack, 1);
      exp_mem[p] = wbuf[i];
      exp_a[i] = p;
      p = pg_next(p);
    end
    bus_stop();
    ptr_m = p;
    wq();
    chk(cap_n - c0 == n, {"R5 strobe count ", tag}, cap_n - c0, n);
    for (int i = 0; i < n; i++) begin
      chk(cap_addr[c0 + i] == exp_a[i], {"R6 strobe address ", tag}, cap_addr[c0 + i], exp_a[i]);
      chk(cap_data[c0 + i] == wbuf[i], {"R5 strobe data ", tag}, cap_data[c0 + i], wbuf[i]);
    end
    chk(commit_n - k0 == ((n > 0) ? 1 : 0), {"R7 commit count ", tag}, commit_n - k0, (n > 0) ? 1 : 0);
    if (wait_done) begin
      while (busy) @(negedge clk);
      wq();
    end
  endtask

  task automatic do_read(input bit set_addr, input logic [6:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    if (set_addr) begin
      bus_start();
      send_byte({4'b1010, STRAP, 1'b0}, ack);
      chk(ack, {"R2 write control ack ", tag}, ack, 1);
      send_byte({1'b0, a}, ack);
      chk(ack, {"R8 address ack ", tag}, ack, 1);
      ptr_m = a;
    end
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    chk(ack, {"R2 read control ack ", tag}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == exp_mem[ptr_m], {"R9 read data ", tag}, b, exp_mem[ptr_m]);
      ptr_m = seq_nxt(ptr_m);
    end
    chk(sda_oe == 1'b0, {"R10 released after no-ack ", tag}, sda_oe, 0);
    bus_stop();
    wq();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack, s;
    logic [7:0] b;
    int c0, k0;
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(sda_oe == 1'b0 && wr_valid == 1'b0 && wr_commit == 1'b0, "R1 outputs after reset",
        {sda_oe, wr_valid, wr_commit}, 0);
    do_read(1'b0, 7'd0, 1, "R1 first current read at 0");

    // R3 mismatches
    c0 = cap_n;
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, ack);
    chk(!ack, "R3 wrong select no ack", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R3 ignored byte no ack", ack, 0);
    send_byte(8'h5A, ack);
    chk(!ack && cap_n == c0, "R3 ignored data no strobe", cap_n - c0, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1110, STRAP, 1'b1}, ack);
    chk(!ack, "R3 wrong code no ack", ack, 0);
    bus_stop();

    // R5 R7 byte write, then R4 polling
    wbuf[0] = 8'hA7;
    do_write(7'h25, 1, 1'b0, "byte write");
    chk(busy == 1'b1, "R4 engine busy precondition", busy, 1);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    chk(!ack, "R4 poll refused while busy", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    chk(!ack, "R4 read refused while busy", ack, 0);
    bus_stop();
    while (busy) @(negedge clk);
    wq();
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    chk(ack, "R4 poll acknowledged after busy", ack, 1);
    bus_stop();

    // R9 current read after write: location after last written
    do_read(1'b0, 7'd0, 1, "current after write");

    // R8 R9 R10 random + sequential across top of array
    do_read(1'b1, 7'h7E, 4, "wrap 7F to 00");

    // R10 no drive after no-ack through extra clocks
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    recv_byte(1'b0, b);
    chk(b == exp_mem[ptr_m], "R9 single read", b, exp_mem[ptr_m]);
    ptr_m = seq_nxt(ptr_m);
    s = 1'b1;
    for (int i = 0; i < 9; i++) begin
      logic t;
      put_bit(1'b1, t);
      s = s & t;
    end
    chk(s == 1'b1, "R10 line left released after no-ack", s, 1);
    bus_stop();

    // R6 page wrap
    for (int i = 0; i < 6; i++) wbuf[i] = 8'(8'hC0 + i);
    do_write(7'h3C, 6, 1'b1, "page wrap");
    do_read(1'b1, 7'h30, 2, "page wrap readback");
    do_read(1'b1, 7'h3C, 4, "page tail readback");

    // R7 address only write: no commit; pointer kept
    do_write(7'h50, 0, 1'b0, "address only");
    chk(busy == 1'b0, "R7 no programming after address only", busy, 0);
    do_read(1'b0, 7'd0, 1, "R8 pointer kept after address only");

    // R12 aborted data byte
    c0 = cap_n; k0 = commit_n;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'h10, ack);
    chk(ack, "R12 address ack before abort", ack, 1);
    ptr_m = 7'h10;
    send_bits(4, 8'h0A);
    bus_stop();
    wq();
    chk(cap_n == c0 && commit_n == k0, "R12 partial byte dropped", cap_n - c0 + commit_n - k0, 0);
    // R12 aborted control byte followed by a full one
    bus_start();
    send_bits(3, 8'h05);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    chk(ack, "R12 control decoded afresh", ack, 1);
    recv_byte(1'b0, b);
    chk(b == exp_mem[ptr_m], "R12 read after abort", b, exp_mem[ptr_m]);
    ptr_m = seq_nxt(ptr_m);
    bus_stop();

    // Random mix
    for (int it = 0; it < 5; it++) begin
      logic [6:0] a;
      int n;
      a = 7'($urandom % 128);
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n, 1'b1, "random write");
      do_read(1'b0, 7'd0, 1, "random current");
      a = 7'($urandom % 128);
      n = 1 + int'($urandom % 6);
      do_read(1'b1, a, n, "random sequential");
    end

    chk(oe_bad == 0 && oe_changes > 0, "R11 drive change timing", oe_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule